// File: doc/BRIEF.md
# Buffered SPI Slave Transmit Path

This block is the byte engine of an SPI slave that runs in mode 0. A one-byte staging buffer sits in front of the outgoing shift register. Software-side writes arrive on a stream port. The serial side samples MOSI on rising SCK, advances MISO on falling SCK, sends MSB first, and treats SS (active low) as the frame enable. SCK, MOSI and SS are brought into the system clock domain by two-flop synchronisers, so the system clock must run at least four times faster than SCK.

When staging is enabled, every write goes into the buffer. At the end of each byte, the buffered byte, if any, moves into the shift register for the next byte. A wait-for-receive control chooses when the first write reaches the wire:
- With wait-for-receive at 0, the first frame carries whatever the shift register already holds.
- With wait-for-receive at 1, a write made while the bus is idle is pulled into the shift register on the following clock.

A write that arrives while the buffer is full is thrown away. Three status flags follow the buffer: data-empty, receive-complete and transfer-complete. Receive-complete and transfer-complete are set on consecutive clocks after the end of a byte and are cleared by writing one.

When staging is disabled, an idle-time write loads the shift register directly.

Top module: `spi_txbuf_slave`

## Requirements
- R1: With `buf_en`=1, a write into an empty buffer stores the byte in the buffer and drives `flag_dre` low on the following clock.
- R2: With `buf_en`=1, a write while `flag_dre` is low is discarded. The buffered byte keeps its old value, and `flag_dre` stays low.
- R3: With `buf_en`=1 and `wait_rx`=0, a buffered byte never enters the shift register while SS is high. The first frame after a write sends the shift register's prior content: the last byte received, or 0x00 after reset.
- R4: With `buf_en`=1 and `wait_rx`=1, a byte written into an empty buffer while SS is high is pulled into the shift register the next clock, and `flag_dre` returns high. This happens only if the shift register holds no unsent loaded byte. That byte goes out in the next frame, and the following write stays buffered.
- R5: At the end of each byte, a buffered byte moves into the shift register and `flag_dre` rises. If the buffer is empty, the shift register takes the byte just received instead.
- R6: `rx_data` takes the received byte at the end of each byte. `flag_rxc` is set exactly one clock after that end-of-byte event.
- R7: `flag_txc` is set one clock after `flag_rxc` is set, and only if the buffer was empty at that end of byte. If a buffered byte was moved for a further frame, `flag_txc` stays clear. The flags behave the same for both values of `wait_rx`.
- R8: Writing 1 to `flag_clr[0]` clears `flag_rxc`, and writing 1 to `flag_clr[1]` clears `flag_txc`. A 0 bit leaves its flag alone. A set in the same clock overrides a clear.
- R9: Serial mode 0: MISO presents the MSB before the first rising SCK, the bit index advances on each later falling SCK, and MOSI is shifted in MSB first on rising SCK.
- R10: Raising SS in the middle of a byte resets the bit position and sets no flag. The next frame resends the shift register content from its MSB.
- R11: With `buf_en`=0, a write while SS is high loads the shift register directly, and `flag_dre` stays high.
- R12: `wr_ready` is always high. The write port never applies back-pressure, and a dropped write is consumed like an accepted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_en | input | 1 | 1 = writes go through the staging buffer |
| wait_rx | input | 1 | 1 = idle writes are pulled into the shift register at once |
| wr_valid | input | 1 | Write strobe for the data register |
| wr_ready | output | 1 | Always 1; the port never stalls |
| wr_data | input | DATA_W | Byte to transmit |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data in |
| ss_n | input | 1 | Slave select, active low |
| miso | output | 1 | Serial data out |
| rx_data | output | DATA_W | Last complete received byte |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 receive-complete, bit 1 transfer-complete |
| flag_dre | output | 1 | High while the staging buffer is empty |
| flag_rxc | output | 1 | Receive-complete flag |
| flag_txc | output | 1 | Transfer-complete flag |

## Verification
The bench replays the write sequence 0x43, 0x44, 0x45, 0x46 with both `wait_rx` settings, where 0x45 must be dropped.

The error modes it targets are these:
- A design that loads the buffer into the shift register too early in `wait_rx`=0 mode would send 0x43 instead of the stale dummy byte.
- A design that lets a full-buffer write overwrite the buffer would send 0x45 instead of 0x44.
- A design that sets transfer-complete whenever a byte ends would raise it while 0x44 or 0x46 is still queued.

A mid-byte SS release checks that no flag fires and that the next frame starts again at the MSB. Seeded random mixes of writes and frames are then run in all three modes and scored against a reference model of buffer, shift register and flags.

// File: rtl/spi_txbuf_pkg.sv
package spi_txbuf_pkg;
  // bit positions inside flag_clr
  localparam int FLG_RXC = 0;
  localparam int FLG_TXC = 1;
  localparam int FLG_N   = 2;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              mosi,
  input  logic              ss_n,
  input  logic              ld,
  input  logic [DATA_W-1:0] ld_data,
  output logic              miso,
  output logic              eob,
  output logic [DATA_W-1:0] rx_byte,
  output logic              ss_idle
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [2:0] pins_s;
  logic       sck_q;
  logic       sck_rise, sck_fall, mosi_s, active;
  logic [CNT_W-1:0]  bit_cnt, out_idx, tx_pos;
  logic [DATA_W-1:0] rx_sh, tx_sh;

  spi_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ss_n, mosi, sck}),
    .q    (pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= pins_s[0];
  end

  assign sck_rise = pins_s[0] & ~sck_q;
  assign sck_fall = ~pins_s[0] & sck_q;
  assign mosi_s   = pins_s[1];
  assign ss_idle  = pins_s[2];
  assign active   = ~pins_s[2];

  assign eob     = active & sck_rise & (bit_cnt == LAST);
  assign rx_byte = {rx_sh[DATA_W-2:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      out_idx <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
    end else begin
      if (!active) begin
        bit_cnt <= '0;
        out_idx <= '0;
      end else begin
        if (sck_rise) begin
          rx_sh   <= rx_byte;
          bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
        end
        if (sck_fall && bit_cnt != '0) out_idx <= out_idx + 1'b1;
      end
      if (ld) begin
        tx_sh   <= ld_data;
        out_idx <= '0;
      end
    end
  end

  assign tx_pos = LAST - out_idx;
  assign miso   = tx_sh[tx_pos];
endmodule

// File: rtl/spi_txbuf_ctrl.sv
module spi_txbuf_ctrl
  import spi_txbuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_en,
  input  logic              wait_rx,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ss_idle,
  input  logic              eob,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [FLG_N-1:0]  flag_clr,
  output logic              ld,
  output logic [DATA_W-1:0] ld_data,
  output logic              buf_full,
  output logic [DATA_W-1:0] buf_data,
  output logic              flag_rxc,
  output logic              flag_txc,
  output logic [DATA_W-1:0] rx_data
);
  logic wr_take, wr_direct, idle_copy;
  logic sh_fresh;
  logic eob_q, nopend_q, txc_go;

  assign wr_take   = buf_en & wr_valid & ~buf_full;
  assign wr_direct = ~buf_en & wr_valid & ss_idle;
  assign idle_copy = buf_en & wait_rx & ss_idle & buf_full & ~sh_fresh;
  assign ld        = eob | idle_copy | wr_direct;

  always_comb begin
    if (eob)            ld_data = buf_full ? buf_data : rx_byte;
    else if (idle_copy) ld_data = buf_data;
    else                ld_data = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      buf_data <= '0;
      sh_fresh <= 1'b0;
      rx_data  <= '0;
    end else begin
      if ((eob || idle_copy) && buf_full) buf_full <= 1'b0;
      if (wr_take) begin
        buf_full <= 1'b1;
        buf_data <= wr_data;
      end
      if (eob) begin
        sh_fresh <= buf_full;
        rx_data  <= rx_byte;
      end else if (idle_copy || wr_direct) begin
        sh_fresh <= 1'b1;
      end
    end
  end

  // flag pipeline: end of byte -> rxc (+1) -> txc (+2)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eob_q    <= 1'b0;
      nopend_q <= 1'b0;
      txc_go   <= 1'b0;
      flag_rxc <= 1'b0;
      flag_txc <= 1'b0;
    end else begin
      eob_q  <= eob;
      if (eob) nopend_q <= ~buf_full;
      txc_go <= eob_q & nopend_q;
      if (eob_q)                  flag_rxc <= 1'b1;
      else if (flag_clr[FLG_RXC]) flag_rxc <= 1'b0;
      if (txc_go)                 flag_txc <= 1'b1;
      else if (flag_clr[FLG_TXC]) flag_txc <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_txbuf_slave.sv
module spi_txbuf_slave
  import spi_txbuf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_en,
  input  logic              wait_rx,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sck,
  input  logic              mosi,
  input  logic              ss_n,
  output logic              miso,
  output logic [DATA_W-1:0] rx_data,
  input  logic [FLG_N-1:0]  flag_clr,
  output logic              flag_dre,
  output logic              flag_rxc,
  output logic              flag_txc
);
  logic              eob, ss_idle, ld, buf_full;
  logic [DATA_W-1:0] rx_byte, ld_data, buf_data;

  spi_bit_engine #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .sck    (sck),
    .mosi   (mosi),
    .ss_n   (ss_n),
    .ld     (ld),
    .ld_data(ld_data),
    .miso   (miso),
    .eob    (eob),
    .rx_byte(rx_byte),
    .ss_idle(ss_idle)
  );

  spi_txbuf_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .buf_en  (buf_en),
    .wait_rx (wait_rx),
    .wr_valid(wr_valid),
    .wr_data (wr_data),
    .ss_idle (ss_idle),
    .eob     (eob),
    .rx_byte (rx_byte),
    .flag_clr(flag_clr),
    .ld      (ld),
    .ld_data (ld_data),
    .buf_full(buf_full),
    .buf_data(buf_data),
    .flag_rxc(flag_rxc),
    .flag_txc(flag_txc),
    .rx_data (rx_data)
  );

  assign wr_ready = 1'b1;
  assign flag_dre = ~buf_full;
endmodule

// File: rtl/spi_txbuf_chk.sv
module spi_txbuf_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              buf_en,
  input logic              wr_valid,
  input logic              eob,
  input logic              buf_full,
  input logic [DATA_W-1:0] buf_data,
  input logic              flag_dre,
  input logic              flag_rxc,
  input logic              flag_txc
);
  // R1
  wr_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && buf_en && !buf_full |=> !flag_dre);

  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && buf_en && buf_full |=> $stable(buf_data));

  // R5
  eob_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eob && buf_full |=> flag_dre);

  // R6
  rxc_after_eob_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eob |=> ##1 flag_rxc);

  // R7
  txc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_txc) |-> $past(flag_rxc));
endmodule

bind spi_txbuf_slave spi_txbuf_chk #(.DATA_W(DATA_W)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .buf_en  (buf_en),
  .wr_valid(wr_valid),
  .eob     (eob),
  .buf_full(buf_full),
  .buf_data(buf_data),
  .flag_dre(flag_dre),
  .flag_rxc(flag_rxc),
  .flag_txc(flag_txc)
);

// File: tb/test_spi_txbuf_slave.sv
module test_spi_txbuf_slave;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       buf_en = 1'b1, wait_rx = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = '0;
  logic       sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic       miso;
  logic [7:0] rx_data;
  logic [1:0] flag_clr = '0;
  logic       flag_dre, flag_rxc, flag_txc;

  int nvec = 0;
  int nerr = 0;

  // reference model
  bit       m_full, m_fresh;
  bit [7:0] m_tb, m_sh;

  always #2 clk = ~clk;

  spi_txbuf_slave i_spi_txbuf_slave (
    .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .wait_rx(wait_rx),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .sck(sck), .mosi(mosi), .ss_n(ss_n), .miso(miso), .rx_data(rx_data),
    .flag_clr(flag_clr), .flag_dre(flag_dre), .flag_rxc(flag_rxc),
    .flag_txc(flag_txc)
  );

  function automatic bit [7:0] exp_next_sh(bit full, bit [7:0] tb, bit [7:0] rx);
    return full ? tb : rx;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input bit be, input bit wr);
    tick(1);
    rst_n = 1'b0; buf_en = be; wait_rx = wr; ss_n = 1'b1; sck = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    m_full = 0; m_fresh = 0; m_tb = '0; m_sh = '0;
  endtask

  task automatic do_write(input bit [7:0] b, input string tag);
    wr_valid = 1'b1; wr_data = b;
    tick(1);
    wr_valid = 1'b0;
    if (buf_en) begin
      if (!m_full) begin m_full = 1; m_tb = b; end
    end else begin
      m_sh = b; m_fresh = 1;
    end
    tick(4);
    if (buf_en && wait_rx && m_full && !m_fresh) begin
      m_sh = m_tb; m_full = 0; m_fresh = 1;
    end
    chk(tag, flag_dre, !m_full);
  endtask

  task automatic do_xfer(input bit [7:0] m, input string tag, input bit partial_clr);
    logic [7:0] got;
    bit [7:0]   exp_miso;
    bit         exp_txc;
    ss_n = 1'b0;
    tick(6);
    for (int i = 7; i >= 0; i--) begin
      mosi = m[i];
      tick(6);
      got[i] = miso;
      sck = 1'b1;
      tick(6);
      sck = 1'b0;
    end
    tick(6);
    ss_n = 1'b1;
    tick(8);
    exp_miso = m_sh;
    exp_txc  = !m_full;
    m_sh     = exp_next_sh(m_full, m_tb, m);
    m_fresh  = m_full;
    m_full   = 0;
    chk({tag, " miso"}, got, exp_miso);
    chk("R6 rx_data", rx_data, m);
    chk("R6 rxc", flag_rxc, 1'b1);
    chk("R7 txc", flag_txc, exp_txc);
    chk("R5 dre", flag_dre, 1'b1);
    if (partial_clr) begin
      flag_clr = 2'b01;
      tick(1);
      flag_clr = 2'b00;
      tick(1);
      chk("R8 rxc cleared", flag_rxc, 1'b0);
      chk("R8 txc kept", flag_txc, exp_txc);
    end
    flag_clr = 2'b11;
    tick(1);
    flag_clr = 2'b00;
    tick(1);
    chk("R8 flags cleared", {flag_rxc, flag_txc}, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));

    // Staged, wait_rx = 0
    do_reset(1'b1, 1'b0);
    chk("R12 ready", wr_ready, 1'b1);
    chk("R1 reset dre", flag_dre, 1'b1);
    chk("R6 reset flags", {flag_rxc, flag_txc}, 2'b00);
    chk("R9 reset miso", miso, 1'b0);
    do_xfer(8'h3C, "R3", 1'b1);
    do_write(8'h43, "R1");
    do_xfer(8'h11, "R3", 1'b0);   // dummy 0x3C goes out
    do_write(8'h44, "R1");
    do_write(8'h45, "R2");        // dropped
    do_xfer(8'h22, "R5", 1'b0);   // 0x43
    do_write(8'h46, "R1");
    do_xfer(8'h33, "R2", 1'b0);   // 0x44, not 0x45
    do_xfer(8'h55, "R7", 1'b1);   // 0x46, txc set
    do_xfer(8'h66, "R3", 1'b0);   // stale 0x55

    // Staged, wait_rx = 1
    do_reset(1'b1, 1'b1);
    do_write(8'h43, "R4");        // pulled in, dre high again
    do_write(8'h44, "R4");
    do_write(8'h45, "R2");
    do_xfer(8'h01, "R4", 1'b0);   // 0x43
    do_write(8'h46, "R1");
    do_xfer(8'h02, "R2", 1'b0);   // 0x44
    do_xfer(8'h03, "R7", 1'b0);   // 0x46

    // Direct mode
    do_reset(1'b0, 1'b0);
    do_write(8'h5A, "R11");
    do_xfer(8'hC3, "R11", 1'b0);
    do_xfer(8'h99, "R11", 1'b0);

    // Mid-byte SS release
    do_reset(1'b1, 1'b1);
    do_write(8'h81, "R4");
    ss_n = 1'b0;
    tick(6);
    for (int i = 0; i < 3; i++) begin
      mosi = 1'b1;
      tick(6); sck = 1'b1;
      tick(6); sck = 1'b0;
    end
    tick(6);
    ss_n = 1'b1;
    tick(10);
    chk("R10 no rxc", flag_rxc, 1'b0);
    chk("R10 no txc", flag_txc, 1'b0);
    do_xfer(8'h7E, "R10", 1'b0);  // 0x81 from its MSB

    // Seeded random mixes in each mode
    for (int seg = 0; seg < 3; seg++) begin
      do_reset(seg != 2, seg == 1);
      for (int k = 0; k < 30; k++) begin
        if ($urandom % 2) do_write(8'($urandom), "R2");
        else              do_xfer(8'($urandom), "R5", 1'b0);
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule